// File: doc/BRIEF.md
# Second-Level Address Translation Walker

This block turns a guest-physical address into a host-physical address by walking a four-level table hierarchy kept in memory. A virtual-machine entry event arms the walker, can enable translation, and loads the physical frame of the top-level table. A virtual-machine exit event disarms the walker. While the walker is disarmed, every request comes back at once with the guest address as the host address.

While translation is armed, an accepted request issues one 8-byte entry read for each level over a single-outstanding memory request/response port. The walk starts at level 4 and ends at a 4 KB page. Each entry carries three permission bits and the frame of the next table, or of the page. The walk stops at the first entry that is not present or that does not grant the requested access. In that case the response carries a violation and the number of the level that failed.

The requester can mark a request as already carrying a guest paging fault for the leaf access. That fault is then reported in place of any result or violation from the second-level walk.

Top module: `slat_walker`

## Requirements
- R1: After reset, xlatActive, rspValid and memReqValid are low and reqReady is high.
- R2: A request accepted while xlatActive is low produces rspValid exactly one cycle later, with rspHpa equal to reqGpa zero-extended, rspViolation low, rspFaultLevel 0, rspGuestFault equal to reqGuestFault, and no memory read.
- R3: A vmEnter pulse with vmEnableXlat high sets xlatActive and captures vmBasePtr bits 51:12 as the root table frame. A vmEnter pulse with vmEnableXlat low clears xlatActive. A vmExit pulse clears xlatActive and takes priority over a vmEnter pulse in the same cycle.
- R4: An armed walk reads level 4 first and level 1 last. The entry address of each level is {table frame, index, 3'b000}. The index is taken from guest address bits 47:39 at level 4, 38:30 at level 3, 29:21 at level 2 and 20:12 at level 1.
- R5: When every level grants the access, rspHpa is {leaf entry bits 51:12, reqGpa bits 11:0}. Entry bits 51:12 of each upper level give the frame of the next table.
- R6: An entry whose bits 2:0 are all zero ends the walk with rspViolation high and rspFaultLevel set to that level (4..1). No further read is issued.
- R7: Entry bit 0 grants read, bit 1 grants write and bit 2 grants execute. reqAccess encodes 0 as read, 1 as write, 2 as execute, and 3 is handled as read. A level whose entry lacks the required bit ends the walk as in R6.
- R8: On an armed walk with reqGuestFault high, the response has rspGuestFault high, rspViolation low, rspFaultLevel 0 and rspHpa 0, whatever the entries hold.
- R9: reqReady is high only while idle. memReqValid is a one-cycle pulse per level. The walker waits any number of cycles for memRspValid. rspValid is a one-cycle pulse.
- R10: The armed or disarmed state is sampled when a request is accepted. A vmExit during a walk does not alter that walk, and later requests are passed through.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| vmEnter | input | 1 | VM entry event pulse |
| vmExit | input | 1 | VM exit event pulse |
| vmEnableXlat | input | 1 | Translation enable, sampled with vmEnter |
| vmBasePtr | input | 52 | Root table pointer, bits 51:12 used |
| reqValid | input | 1 | Translation request valid |
| reqReady | output | 1 | Walker idle and accepting |
| reqGpa | input | 48 | Guest-physical address |
| reqAccess | input | 2 | Access type: 0 read, 1 write, 2 execute, 3 read |
| reqGuestFault | input | 1 | Guest paging fault already flagged for the leaf |
| memReqValid | output | 1 | Entry read request pulse |
| memReqAddr | output | 52 | Entry byte address |
| memRspValid | input | 1 | Entry read data valid |
| memRspData | input | 64 | Entry contents |
| rspValid | output | 1 | Translation response pulse |
| rspHpa | output | 52 | Host-physical address |
| rspViolation | output | 1 | Second-level violation |
| rspGuestFault | output | 1 | Guest fault reported |
| rspFaultLevel | output | 3 | Level of the violation, 0 if none |
| xlatActive | output | 1 | Translation armed |

## Verification
The bench aims at the walk order, sending each level's index from the wrong address slice or starting at the wrong level. Such a design would read addresses that differ from the queued expected ones. It also probes permission gaps at one middle level and handles access code 3 as read. A mask that is off by one, or a walk that ignores upper levels, would then pass a request that must fail, or report the wrong level. Not-present entries at levels 4 and 3 check that the walk halts with no extra reads. Guest-fault requests over both failing and good chains must hide the violation. A vmExit in the middle of a walk, a simultaneous exit and entry, and a re-entry with a new root catch a walker that fails to sample activation at acceptance, gives the wrong event priority, or keeps a stale root.

// File: rtl/slat_pkg.sv
package slat_pkg;

  typedef enum logic [1:0] {
    ACC_READ  = 2'd0,
    ACC_WRITE = 2'd1,
    ACC_EXEC  = 2'd2,
    ACC_ALT   = 2'd3
  } acc_e;

  // strobes from control to datapath
  typedef struct packed {
    logic capture;     // latch request, load root frame, start at top level
    logic passDone;    // untranslated response
    logic advance;     // step down one level using the entry frame
    logic finishOk;    // leaf granted
    logic finishViol;  // entry rejected
  } ctl_s;

  // permission bits required per access type: bit0 read, bit1 write, bit2 exec
  function automatic logic [2:0] needMask(input logic [1:0] acc);
    case (acc)
      ACC_WRITE: needMask = 3'b010;
      ACC_EXEC:  needMask = 3'b100;
      default:   needMask = 3'b001;
    endcase
  endfunction

endpackage

// File: rtl/slat_ctrl.sv
module slat_ctrl
  import slat_pkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic reqValid,
  input  logic xlatActive,
  input  logic memRspValid,
  input  logic entryFault,
  input  logic atLeaf,
  output ctl_s ctl,
  output logic reqReady,
  output logic memReqValid,
  output logic rspValid
);

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_WAIT, S_DONE} state_e;
  state_e stateQ, stateD;

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= S_IDLE;
    else       stateQ <= stateD;
  end

  always_comb begin
    stateD      = stateQ;
    ctl         = '0;
    reqReady    = 1'b0;
    memReqValid = 1'b0;
    rspValid    = 1'b0;
    case (stateQ)
      S_IDLE: begin
        reqReady = 1'b1;
        if (reqValid) begin
          ctl.capture = 1'b1;
          if (xlatActive) begin
            stateD = S_FETCH;
          end else begin
            ctl.passDone = 1'b1;
            stateD       = S_DONE;
          end
        end
      end
      S_FETCH: begin
        memReqValid = 1'b1;
        stateD      = S_WAIT;
      end
      S_WAIT: begin
        if (memRspValid) begin
          if (entryFault) begin
            ctl.finishViol = 1'b1;
            stateD         = S_DONE;
          end else if (atLeaf) begin
            ctl.finishOk = 1'b1;
            stateD       = S_DONE;
          end else begin
            ctl.advance = 1'b1;
            stateD      = S_FETCH;
          end
        end
      end
      default: begin
        rspValid = 1'b1;
        stateD   = S_IDLE;
      end
    endcase
  end

endmodule

// File: rtl/slat_dpath.sv
module slat_dpath
  import slat_pkg::*;
#(
  parameter int GPA_W  = 48,
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int ENT_W  = 64,
  parameter int PERM_W = 3,
  localparam int FRAME_W = PA_W - OFF_W,
  localparam int LVL_W   = $clog2(LEVELS),
  localparam int FLV_W   = $clog2(LEVELS + 1),
  localparam int ESZ_W   = $clog2(ENT_W / 8)
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctl_s              ctl,
  input  logic              vmEnter,
  input  logic              vmExit,
  input  logic              vmEnableXlat,
  input  logic [PA_W-1:0]   vmBasePtr,
  input  logic [GPA_W-1:0]  reqGpa,
  input  logic [1:0]        reqAccess,
  input  logic              reqGuestFault,
  input  logic [ENT_W-1:0]  memRspData,
  output logic              xlatActive,
  output logic [PA_W-1:0]   memReqAddr,
  output logic [PA_W-1:0]   rspHpa,
  output logic              rspViolation,
  output logic              rspGuestFault,
  output logic [FLV_W-1:0]  rspFaultLevel,
  output logic              entryFault,
  output logic              atLeaf
);

  // activation state
  logic               activeQ;
  logic [FRAME_W-1:0] rootQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      activeQ <= 1'b0;
      rootQ   <= '0;
    end else if (vmExit) begin
      activeQ <= 1'b0;
    end else if (vmEnter) begin
      activeQ <= vmEnableXlat;
      if (vmEnableXlat) rootQ <= vmBasePtr[PA_W-1:OFF_W];
    end
  end
  assign xlatActive = activeQ;

  // walk state
  logic [GPA_W-1:0]   gpaQ;
  logic [1:0]         accQ;
  logic               gfQ;
  logic [FRAME_W-1:0] frameQ;
  logic [LVL_W-1:0]   lvlQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      gpaQ   <= '0;
      accQ   <= '0;
      gfQ    <= 1'b0;
      frameQ <= '0;
      lvlQ   <= '0;
    end else if (ctl.capture) begin
      gpaQ   <= reqGpa;
      accQ   <= reqAccess;
      gfQ    <= reqGuestFault;
      frameQ <= rootQ;
      lvlQ   <= LVL_W'(LEVELS - 1);
    end else if (ctl.advance) begin
      frameQ <= memRspData[PA_W-1:OFF_W];
      lvlQ   <= lvlQ - 1'b1;
    end
  end

  // index slice per level
  logic [IDX_W-1:0] idxCand [LEVELS];
  for (genvar g = 0; g < LEVELS; g++) begin : g_idx
    assign idxCand[g] = gpaQ[OFF_W + IDX_W*g +: IDX_W];
  end

  assign memReqAddr = {frameQ, idxCand[lvlQ], {ESZ_W{1'b0}}};

  // entry checks
  logic [PERM_W-1:0] perm;
  logic [PERM_W-1:0] need;
  logic              notPresent;
  logic              lacksPerm;
  assign perm       = memRspData[PERM_W-1:0];
  assign need       = needMask(accQ);
  assign notPresent = (perm == '0);
  assign lacksPerm  = ((perm & need) != need);
  assign entryFault = notPresent | lacksPerm;
  assign atLeaf     = (lvlQ == '0);

  // response registers
  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspHpa        <= '0;
      rspViolation  <= 1'b0;
      rspGuestFault <= 1'b0;
      rspFaultLevel <= '0;
    end else if (ctl.passDone) begin
      rspHpa        <= PA_W'(reqGpa);
      rspViolation  <= 1'b0;
      rspGuestFault <= reqGuestFault;
      rspFaultLevel <= '0;
    end else if (ctl.finishOk || ctl.finishViol) begin
      if (gfQ) begin
        rspHpa        <= '0;
        rspViolation  <= 1'b0;
        rspGuestFault <= 1'b1;
        rspFaultLevel <= '0;
      end else if (ctl.finishViol) begin
        rspHpa        <= '0;
        rspViolation  <= 1'b1;
        rspGuestFault <= 1'b0;
        rspFaultLevel <= FLV_W'(lvlQ) + FLV_W'(1);
      end else begin
        rspHpa        <= {memRspData[PA_W-1:OFF_W], gpaQ[OFF_W-1:0]};
        rspViolation  <= 1'b0;
        rspGuestFault <= 1'b0;
        rspFaultLevel <= '0;
      end
    end
  end

  logic unusedBits;
  assign unusedBits = ^{memRspData[ENT_W-1:PA_W], memRspData[OFF_W-1:PERM_W],
                        vmBasePtr[OFF_W-1:0]};

endmodule

// File: rtl/slat_walker.sv
module slat_walker
  import slat_pkg::*;
#(
  parameter int GPA_W  = 48,
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  parameter int IDX_W  = 9,
  parameter int OFF_W  = 12,
  parameter int ENT_W  = 64,
  localparam int FLV_W = $clog2(LEVELS + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             vmEnter,
  input  logic             vmExit,
  input  logic             vmEnableXlat,
  input  logic [PA_W-1:0]  vmBasePtr,
  input  logic             reqValid,
  output logic             reqReady,
  input  logic [GPA_W-1:0] reqGpa,
  input  logic [1:0]       reqAccess,
  input  logic             reqGuestFault,
  output logic             memReqValid,
  output logic [PA_W-1:0]  memReqAddr,
  input  logic             memRspValid,
  input  logic [ENT_W-1:0] memRspData,
  output logic             rspValid,
  output logic [PA_W-1:0]  rspHpa,
  output logic             rspViolation,
  output logic             rspGuestFault,
  output logic [FLV_W-1:0] rspFaultLevel,
  output logic             xlatActive
);

  ctl_s ctl;
  logic entryFault;
  logic atLeaf;

  slat_ctrl ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .xlatActive (xlatActive),
    .memRspValid(memRspValid),
    .entryFault (entryFault),
    .atLeaf     (atLeaf),
    .ctl        (ctl),
    .reqReady   (reqReady),
    .memReqValid(memReqValid),
    .rspValid   (rspValid)
  );

  slat_dpath #(
    .GPA_W (GPA_W),
    .PA_W  (PA_W),
    .LEVELS(LEVELS),
    .IDX_W (IDX_W),
    .OFF_W (OFF_W),
    .ENT_W (ENT_W)
  ) dpath_i (
    .clk          (clk),
    .rstN         (rstN),
    .ctl          (ctl),
    .vmEnter      (vmEnter),
    .vmExit       (vmExit),
    .vmEnableXlat (vmEnableXlat),
    .vmBasePtr    (vmBasePtr),
    .reqGpa       (reqGpa),
    .reqAccess    (reqAccess),
    .reqGuestFault(reqGuestFault),
    .memRspData   (memRspData),
    .xlatActive   (xlatActive),
    .memReqAddr   (memReqAddr),
    .rspHpa       (rspHpa),
    .rspViolation (rspViolation),
    .rspGuestFault(rspGuestFault),
    .rspFaultLevel(rspFaultLevel),
    .entryFault   (entryFault),
    .atLeaf       (atLeaf)
  );

endmodule

// File: rtl/slat_walker_chk.sv
module slat_walker_chk #(
  parameter int GPA_W  = 48,
  parameter int PA_W   = 52,
  parameter int LEVELS = 4,
  localparam int FLV_W = $clog2(LEVELS + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             vmEnter,
  input logic             vmExit,
  input logic             vmEnableXlat,
  input logic             reqValid,
  input logic             reqReady,
  input logic [GPA_W-1:0] reqGpa,
  input logic             memReqValid,
  input logic             rspValid,
  input logic [PA_W-1:0]  rspHpa,
  input logic             rspViolation,
  input logic             rspGuestFault,
  input logic [FLV_W-1:0] rspFaultLevel,
  input logic             xlatActive
);

  // R2
  pass_through_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && !xlatActive) |=>
      (rspValid && !rspViolation &&
       rspHpa == {{(PA_W-GPA_W){1'b0}}, $past(reqGpa)}));

  // R3
  exit_disarms_chk: assert property (@(posedge clk) disable iff (!rstN)
    vmExit |=> !xlatActive);

  // R3
  enter_arms_chk: assert property (@(posedge clk) disable iff (!rstN)
    (vmEnter && !vmExit && vmEnableXlat) |=> xlatActive);

  // R6
  viol_level_chk: assert property (@(posedge clk) disable iff (!rstN)
    (rspValid && rspViolation) |->
      (rspFaultLevel >= FLV_W'(1) && rspFaultLevel <= FLV_W'(LEVELS) && !rspGuestFault));

  // R9
  mem_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    memReqValid |=> !memReqValid);

  // R9
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R9
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);

endmodule

bind slat_walker slat_walker_chk #(
  .GPA_W (GPA_W),
  .PA_W  (PA_W),
  .LEVELS(LEVELS)
) chk_i (
  .clk          (clk),
  .rstN         (rstN),
  .vmEnter      (vmEnter),
  .vmExit       (vmExit),
  .vmEnableXlat (vmEnableXlat),
  .reqValid     (reqValid),
  .reqReady     (reqReady),
  .reqGpa       (reqGpa),
  .memReqValid  (memReqValid),
  .rspValid     (rspValid),
  .rspHpa       (rspHpa),
  .rspViolation (rspViolation),
  .rspGuestFault(rspGuestFault),
  .rspFaultLevel(rspFaultLevel),
  .xlatActive   (xlatActive)
);

// File: tb/slat_walker_tb_top.sv
`timescale 1ns/1ps
module slat_walker_tb_top;

  localparam int CLK_NS = 8;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        vmEnter = 1'b0, vmExit = 1'b0, vmEnableXlat = 1'b0;
  logic [51:0] vmBasePtr = '0;
  logic        reqValid = 1'b0;
  logic        reqReady;
  logic [47:0] reqGpa = '0;
  logic [1:0]  reqAccess = '0;
  logic        reqGuestFault = 1'b0;
  logic        memReqValid;
  logic [51:0] memReqAddr;
  logic        memRspValid = 1'b0;
  logic [63:0] memRspData = '0;
  logic        rspValid;
  logic [51:0] rspHpa;
  logic        rspViolation, rspGuestFault;
  logic [2:0]  rspFaultLevel;
  logic        xlatActive;

  always #(CLK_NS/2) clk = ~clk;

  slat_walker dut_i (
    .clk(clk), .rstN(rstN), .vmEnter(vmEnter), .vmExit(vmExit),
    .vmEnableXlat(vmEnableXlat), .vmBasePtr(vmBasePtr),
    .reqValid(reqValid), .reqReady(reqReady), .reqGpa(reqGpa),
    .reqAccess(reqAccess), .reqGuestFault(reqGuestFault),
    .memReqValid(memReqValid), .memReqAddr(memReqAddr),
    .memRspValid(memRspValid), .memRspData(memRspData),
    .rspValid(rspValid), .rspHpa(rspHpa), .rspViolation(rspViolation),
    .rspGuestFault(rspGuestFault), .rspFaultLevel(rspFaultLevel),
    .xlatActive(xlatActive)
  );

  int total = 0;
  int bad = 0;
  bit finished = 0;

  // behavioural memory and model state
  logic [63:0] memArr [logic [51:0]];
  logic [51:0] expAddr [$];
  bit          modelActive = 0;
  logic [39:0] modelRoot = '0;

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mkEnt(input logic [39:0] frame, input logic [2:0] perm);
    return {12'h0, frame, 9'h0, perm};
  endfunction

  function automatic logic [63:0] rdMem(input logic [51:0] a);
    return memArr.exists(a) ? memArr[a] : 64'h0;
  endfunction

  function automatic logic [51:0] entAddr(input logic [39:0] frame, input logic [47:0] gpa, input int lvl);
    logic [8:0] ix;
    ix = gpa[12 + 9*(lvl-1) +: 9];
    return {frame, ix, 3'b000};
  endfunction

  // write a full chain of entries for gpa under root
  task automatic mapChain(input logic [39:0] root, input logic [47:0] gpa,
                          input logic [39:0] f3, input logic [39:0] f2,
                          input logic [39:0] f1, input logic [39:0] leaf,
                          input logic [2:0] p4, input logic [2:0] p3,
                          input logic [2:0] p2, input logic [2:0] p1);
    memArr[entAddr(root, gpa, 4)] = mkEnt(f3, p4);
    memArr[entAddr(f3, gpa, 3)]   = mkEnt(f2, p3);
    memArr[entAddr(f2, gpa, 2)]   = mkEnt(f1, p2);
    memArr[entAddr(f1, gpa, 1)]   = mkEnt(leaf, p1);
  endtask

  // behavioural expectation of one armed walk
  task automatic modelWalk(input logic [47:0] gpa, input logic [1:0] acc, input bit gf,
                           output logic [51:0] hpa, output bit viol,
                           output bit gfo, output int lvl);
    logic [39:0] fr;
    logic [2:0]  need;
    fr   = modelRoot;
    need = (acc == 2'd1) ? 3'b010 : (acc == 2'd2) ? 3'b100 : 3'b001;
    hpa = '0; viol = 0; gfo = 0; lvl = 0;
    for (int l = 4; l >= 1; l--) begin
      logic [51:0] a;
      logic [63:0] e;
      a = entAddr(fr, gpa, l);
      expAddr.push_back(a);
      e = rdMem(a);
      if ((e[2:0] & need) != need) begin
        viol = 1; lvl = l;
        break;
      end
      fr = e[51:12];
      if (l == 1) hpa = {fr, gpa[11:0]};
    end
    if (gf) begin
      gfo = 1; viol = 0; lvl = 0; hpa = '0;
    end
  endtask

  task automatic vmPulse(input bit enter, input bit ex, input bit en, input logic [51:0] base);
    @(negedge clk);
    vmEnter = enter; vmExit = ex; vmEnableXlat = en; vmBasePtr = base;
    @(negedge clk);
    vmEnter = 0; vmExit = 0; vmEnableXlat = 0;
    if (ex) modelActive = 0;
    else if (enter) begin
      modelActive = en;
      if (en) modelRoot = base[51:12];
    end
  endtask

  task automatic doXlat(input string tag, input logic [47:0] gpa, input logic [1:0] acc,
                        input bit gf, input int lat, input bit exitMid);
    logic [51:0] eHpa;
    bit eViol, eGf;
    int eLvl;
    bit armed;
    int cycles;
    bit exitPending;
    armed = modelActive;
    expAddr.delete();
    if (armed) modelWalk(gpa, acc, gf, eHpa, eViol, eGf, eLvl);
    else begin
      eHpa = {4'h0, gpa}; eViol = 0; eGf = gf; eLvl = 0;
    end
    exitPending = exitMid;
    @(negedge clk);
    chk(reqReady == 1'b1, "R9", "ready while idle", reqReady, 1);
    reqValid = 1; reqGpa = gpa; reqAccess = acc; reqGuestFault = gf;
    @(negedge clk);
    reqValid = 0;
    cycles = 1;
    forever begin
      if (rspValid) begin
        if (!armed) chk(cycles == 1, "R2", "pass latency", cycles, 1);
        chk(rspHpa == eHpa, tag, "rspHpa", rspHpa, eHpa);
        chk(rspViolation == eViol, tag, "rspViolation", rspViolation, eViol);
        chk(rspGuestFault == eGf, tag, "rspGuestFault", rspGuestFault, eGf);
        chk(rspFaultLevel == 3'(eLvl), tag, "rspFaultLevel", rspFaultLevel, eLvl);
        chk(expAddr.size() == 0, "R6", "reads left unissued", expAddr.size(), 0);
        @(negedge clk);
        chk(rspValid == 1'b0, "R9", "response pulse width", rspValid, 0);
        break;
      end else if (memReqValid) begin
        logic [51:0] ea;
        logic [63:0] d;
        if (expAddr.size() == 0) begin
          chk(0, "R6", "unexpected entry read", memReqAddr, 0);
          ea = memReqAddr;
        end else begin
          ea = expAddr.pop_front();
          chk(memReqAddr == ea, "R4", "entry address", memReqAddr, ea);
        end
        d = rdMem(memReqAddr);
        @(negedge clk); cycles++;
        chk(memReqValid == 1'b0, "R9", "read pulse width", memReqValid, 0);
        for (int k = 0; k < lat; k++) begin
          vmExit = exitPending;
          @(negedge clk); cycles++;
          vmExit = 0;
          if (exitPending) modelActive = 0;
          exitPending = 0;
          chk(rspValid == 1'b0 && reqReady == 1'b0, "R9", "waits for memory", rspValid, 0);
        end
        memRspValid = 1; memRspData = d;
        @(negedge clk); cycles++;
        memRspValid = 0; memRspData = 64'hFFFF_FFFF_FFFF_FFFF;
      end else begin
        @(negedge clk); cycles++;
      end
    end
  endtask

  // watchdog
  initial begin
    #(CLK_NS * 100000);
    if (!finished) begin
      bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  localparam logic [47:0] G1 = {9'd5, 9'd300, 9'd7, 9'd511, 12'hABC};
  localparam logic [47:0] G2 = {9'd5, 9'd300, 9'd7, 9'd12, 12'h004};
  localparam logic [47:0] G3 = {9'd5, 9'd300, 9'd9, 9'd1, 12'hFF8};
  localparam logic [47:0] G4 = {9'd5, 9'd88, 9'd2, 9'd3, 12'h010};
  localparam logic [47:0] G5 = {9'd400, 9'd1, 9'd1, 9'd1, 12'h000};

  initial begin
    // tables under root 0x10
    mapChain(40'h10, G1, 40'h20, 40'h30, 40'h40, 40'h12345, 3'b111, 3'b111, 3'b111, 3'b111);
    memArr[entAddr(40'h40, G2, 1)] = mkEnt(40'hABCDE, 3'b101);
    memArr[entAddr(40'h30, G3, 2)] = mkEnt(40'h60, 3'b110);
    memArr[entAddr(40'h60, G3, 1)] = mkEnt(40'h777, 3'b111);
    // tables under root 0x50
    mapChain(40'h50, G1, 40'h51, 40'h52, 40'h53, 40'hFEDCB, 3'b001, 3'b001, 3'b001, 3'b001);

    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1
    chk(xlatActive == 0, "R1", "xlatActive after reset", xlatActive, 0);
    chk(rspValid == 0, "R1", "rspValid after reset", rspValid, 0);
    chk(memReqValid == 0, "R1", "memReqValid after reset", memReqValid, 0);
    chk(reqReady == 1, "R1", "reqReady after reset", reqReady, 1);

    // R2 disarmed pass-through
    doXlat("R2", 48'hABCD_1234_5678, 2'd1, 0, 0, 0);
    doXlat("R2", G1, 2'd0, 1, 0, 0);

    // R3 arm with root 0x10
    vmPulse(1, 0, 1, {40'h10, 12'hFFF});
    chk(xlatActive == 1, "R3", "armed after entry", xlatActive, 1);

    // R4 R5 full walks, varying memory latency
    doXlat("R5", G1, 2'd0, 0, 0, 0);
    doXlat("R5", G1, 2'd1, 0, 1, 0);
    doXlat("R4", G1, 2'd2, 0, 3, 0);
    doXlat("R5", G2, 2'd2, 0, 2, 0);

    // R7 permission gaps
    doXlat("R7", G2, 2'd1, 0, 0, 0);
    doXlat("R7", G3, 2'd0, 0, 1, 0);
    doXlat("R7", G3, 2'd1, 0, 0, 0);
    doXlat("R7", G3, 2'd3, 0, 0, 0);

    // R6 not present at levels 3 and 4
    doXlat("R6", G4, 2'd0, 0, 1, 0);
    doXlat("R6", G5, 2'd0, 0, 0, 0);

    // R8 guest fault priority
    doXlat("R8", G4, 2'd0, 1, 0, 0);
    doXlat("R8", G1, 2'd0, 1, 1, 0);
    doXlat("R8", G3, 2'd0, 1, 0, 0);

    // R10 exit during walk: walk finishes translated, later pass-through
    doXlat("R10", G1, 2'd0, 0, 2, 1);
    chk(xlatActive == 0, "R10", "disarmed after mid-walk exit", xlatActive, 0);
    doXlat("R10", G1, 2'd0, 0, 0, 0);

    // R3 entry without enable, and exit priority
    vmPulse(1, 0, 1, {40'h10, 12'h0});
    vmPulse(1, 0, 0, {40'h50, 12'h0});
    chk(xlatActive == 0, "R3", "entry without enable", xlatActive, 0);
    doXlat("R3", G2, 2'd0, 0, 0, 0);
    vmPulse(1, 1, 1, {40'h50, 12'h0});
    chk(xlatActive == 0, "R3", "exit beats entry", xlatActive, 0);

    // R3 re-entry with a new root
    vmPulse(1, 0, 1, {40'h50, 12'h0});
    chk(xlatActive == 1, "R3", "re-armed", xlatActive, 1);
    doXlat("R3", G1, 2'd0, 0, 1, 0);
    doXlat("R7", G1, 2'd1, 0, 0, 0);

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule